// File: doc/BRIEF.md
# Configurable SRAM Read Output Pipeline

This block is the last stage of a synchronous SRAM read path. Each clock cycle the access controller gives it at most one command: a read, which carries the word fetched from the array, a write, or a deselect. The block turns these commands into a 72-bit data bus and a drive-enable result that the pad ring uses to switch the bidirectional drivers. Two static mode inputs set its timing. The first chooses flow-through latency, where data is taken from the capture register without the output register, or pipelined latency, where data passes through one more rising-edge register. The second chooses single-cycle or dual-cycle deselect, which sets how many edges pass before the drivers turn off after a deselect.

The read stream uses valid-only flow control. A word is offered with `rd_valid_i` and is taken on every rising edge it is offered. There is no ready signal and no back-pressure, because an SRAM data bus cannot stall its reader. Consecutive reads come out one per cycle, in the order they were offered. An asynchronous output-enable input gates the drive-enable without waiting for a clock edge. The data bus keeps its value while drive is off. The integrator ties `pipe_en_i` high and `dcd_en_i` low for the default configuration, which is pipelined timing with single-cycle deselect. The modes may only change while reset is asserted.

Top module: `sram_rdout_pipe`

## Requirements
- R1: While reset is asserted, and right after it is released, `dq_drv_o` is 0 and `dq_o` is all zeros.
- R2: With `pipe_en_i`=0 (flow-through), a read word offered before rising edge N is on `dq_o` with `dq_drv_o`=1 (given `oe_i`=1) directly after edge N.
- R3: With `pipe_en_i`=1 (pipelined), a read word offered before edge N is on `dq_o` with `dq_drv_o`=1 directly after edge N+1, and drive is still 0 directly after edge N if nothing was driven before.
- R4: A cycle with no command (all of `rd_valid_i`, `wr_valid_i` and `desel_i` low) leaves `dq_o` and `dq_drv_o` unchanged.
- R5: A write turns drive off at the same stage at which a read would turn it on: directly after edge N in flow-through mode, and after edge N+1 in pipelined mode. `dq_o` keeps its value.
- R6: With `dcd_en_i`=0 (single-cycle deselect), a deselect captured at edge N turns `dq_drv_o` off directly after edge N, in both latency modes.
- R7: With `dcd_en_i`=1 (dual-cycle deselect), a deselect captured at edge N leaves drive unchanged for one cycle and turns it off directly after edge N+1, in both latency modes, unless a read captured at edge N+1 becomes visible at that edge.
- R8: `oe_i`=0 forces `dq_drv_o` to 0 at once, with no clock edge needed. `dq_o` is not changed. `oe_i` returning to 1 restores the drive state at once.
- R9: When more than one command is asserted in a cycle, a read takes priority over a write, and a write takes priority over a deselect.
- R10: Reads offered back to back are all accepted, with no back-pressure, and come out one per cycle in the order offered (the 1-1-1 beats of a burst).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_en_i | input | 1 | 1 = pipelined latency, 0 = flow-through (static) |
| dcd_en_i | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle (static) |
| oe_i | input | 1 | Asynchronous output enable, active high |
| rd_valid_i | input | 1 | Read word offered this cycle |
| rd_data_i | input | 72 | Read word from the array |
| wr_valid_i | input | 1 | Write cycle |
| desel_i | input | 1 | Deselect cycle |
| dq_o | output | 72 | Output data bus, held while not driven |
| dq_drv_o | output | 1 | Drive enable for the data pads |

## Verification
Two things can land on the same cycle. The trailing hold of a dual-cycle deselect can meet a read that arrives on the very next edge, and then the new data must win over the turn-off. The bench provokes this in flow-through dual-cycle mode by placing a read directly after a deselect. It expects drive to stay on and the new word to be on the bus after that edge. The bench also provokes a write and a deselect in the same cycle, and judges that the write's immediate turn-off wins over the one-cycle hold.

// File: rtl/sram_rdout_pkg.sv
package sram_rdout_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_DESEL = 2'd3
  } rdout_cmd_e;

  // Read beats write, write beats deselect.
  function automatic rdout_cmd_e cmd_decode(input logic rd, input logic wr, input logic ds);
    if (rd)      return CMD_READ;
    else if (wr) return CMD_WRITE;
    else if (ds) return CMD_DESEL;
    else         return CMD_IDLE;
  endfunction

endpackage

// File: rtl/sram_rdout_capture.sv
module sram_rdout_capture
  import sram_rdout_pkg::*;
#(
  parameter int DATA_W = 72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rdout_cmd_e        cmd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              cap_vld_o,
  output logic [DATA_W-1:0] cap_data_o,
  output logic              cap_desel_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_vld_o   <= 1'b0;
      cap_data_o  <= '0;
      cap_desel_o <= 1'b0;
    end else begin
      cap_desel_o <= (cmd_i == CMD_DESEL);
      unique case (cmd_i)
        CMD_READ: begin
          cap_vld_o  <= 1'b1;
          cap_data_o <= data_i;
        end
        CMD_WRITE, CMD_DESEL: cap_vld_o <= 1'b0;
        default: ;
      endcase
    end
  end

  // R5 / R4: only a read may replace the captured word
  assert_hold_on_nonread_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_READ) |=> (cap_data_o == $past(cap_data_o)));

  // R2: a read is captured with its data on the edge it is offered
  assert_read_captured_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_READ) |=> (cap_vld_o && cap_data_o == $past(data_i)));

endmodule

// File: rtl/sram_rdout_delay.sv
module sram_rdout_delay #(
  parameter int DATA_W = 72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_vld_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic              pip_vld_o,
  output logic [DATA_W-1:0] pip_data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pip_vld_o  <= 1'b0;
      pip_data_o <= '0;
    end else begin
      pip_vld_o  <= cap_vld_i;
      pip_data_o <= cap_data_i;
    end
  end

endmodule

// File: rtl/sram_rdout_select.sv
module sram_rdout_select #(
  parameter int DATA_W = 72
) (
  input  logic              pipe_en_i,
  input  logic              dcd_en_i,
  input  logic              cap_vld_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              cap_desel_i,
  input  logic              pip_vld_i,
  input  logic [DATA_W-1:0] pip_data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);

  always_comb begin
    unique case ({pipe_en_i, dcd_en_i})
      2'b10: begin  // pipelined, single-cycle deselect
        vld_o  = pip_vld_i & ~cap_desel_i;
        data_o = pip_data_i;
      end
      2'b11: begin  // pipelined, dual-cycle deselect
        vld_o  = pip_vld_i;
        data_o = pip_data_i;
      end
      2'b01: begin  // flow-through, dual-cycle: hold one cycle after deselect
        vld_o  = cap_vld_i | (cap_desel_i & pip_vld_i);
        data_o = cap_data_i;
      end
      default: begin  // flow-through, single-cycle
        vld_o  = cap_vld_i;
        data_o = cap_data_i;
      end
    endcase
  end

endmodule

// File: rtl/sram_rdout_pipe.sv
module sram_rdout_pipe
  import sram_rdout_pkg::*;
#(
  parameter int DATA_W = 72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_en_i,
  input  logic              dcd_en_i,
  input  logic              oe_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              wr_valid_i,
  input  logic              desel_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_drv_o
);

  rdout_cmd_e        cmd;
  logic              cap_vld, cap_desel, pip_vld, sel_vld;
  logic [DATA_W-1:0] cap_data, pip_data;

  assign cmd = cmd_decode(rd_valid_i, wr_valid_i, desel_i);

  sram_rdout_capture #(.DATA_W(DATA_W)) cap_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .data_i      (rd_data_i),
    .cap_vld_o   (cap_vld),
    .cap_data_o  (cap_data),
    .cap_desel_o (cap_desel)
  );

  sram_rdout_delay #(.DATA_W(DATA_W)) dly_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_vld_i  (cap_vld),
    .cap_data_i (cap_data),
    .pip_vld_o  (pip_vld),
    .pip_data_o (pip_data)
  );

  sram_rdout_select #(.DATA_W(DATA_W)) sel_i (
    .pipe_en_i   (pipe_en_i),
    .dcd_en_i    (dcd_en_i),
    .cap_vld_i   (cap_vld),
    .cap_data_i  (cap_data),
    .cap_desel_i (cap_desel),
    .pip_vld_i   (pip_vld),
    .pip_data_i  (pip_data),
    .vld_o       (sel_vld),
    .data_o      (dq_o)
  );

  // Output enable acts without a clock.
  assign dq_drv_o = oe_i & sel_vld;

  // Assertion support: one-cycle history of the command stream.
  logic              hist_desel, hist_rd;
  logic [DATA_W-1:0] hist_data;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_desel <= 1'b0;
      hist_rd    <= 1'b0;
      hist_data  <= '0;
    end else begin
      hist_desel <= (cmd == CMD_DESEL);
      hist_rd    <= (cmd == CMD_READ);
      hist_data  <= rd_data_i;
    end
  end

  // R2: flow-through data appears right after the capturing edge
  assert_flow_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_en_i && cmd == CMD_READ) |=> (dq_o == $past(rd_data_i)));

  // R3: pipelined data appears one edge later
  assert_pipe_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_en_i && hist_rd) |=> (dq_o == $past(hist_data)));

  // R6: single-cycle deselect turns the drivers off at once
  assert_scd_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dcd_en_i && cmd == CMD_DESEL) |=> !dq_drv_o);

  // R7: dual-cycle deselect turns the drivers off one edge later
  assert_dcd_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcd_en_i && hist_desel && cmd != CMD_READ) |=> !dq_drv_o);

endmodule

// File: tb/sram_rdout_pipe_tb.sv
module sram_rdout_pipe_tb_top;
  localparam int W = 72;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pipe_en = 1'b1, dcd_en = 1'b0, oe = 1'b1;
  logic rd_v = 1'b0, wr_v = 1'b0, ds = 1'b0;
  logic [W-1:0] rd_d = '0;
  logic [W-1:0] dq;
  logic drv;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sram_rdout_pipe #(.DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pipe_en_i(pipe_en), .dcd_en_i(dcd_en), .oe_i(oe),
    .rd_valid_i(rd_v), .rd_data_i(rd_d), .wr_valid_i(wr_v), .desel_i(ds),
    .dq_o(dq), .dq_drv_o(drv)
  );

  task automatic chk_d(string req, logic [W-1:0] exp);
    n_chk++;
    if (dq !== exp) begin
      n_fail++;
      $display("FAIL %s dq act=%h exp=%h", req, dq, exp);
    end
  endtask

  task automatic chk_v(string req, logic exp);
    n_chk++;
    if (drv !== exp) begin
      n_fail++;
      $display("FAIL %s drv act=%b exp=%b", req, drv, exp);
    end
  endtask

  // Reset with the given modes; returns 1 ns after a clock edge.
  task automatic do_reset(logic p, logic d);
    rst_n = 1'b0; rd_v = 0; wr_v = 0; ds = 0; oe = 1;
    pipe_en = p; dcd_en = d;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // Present one command, pass one edge, return 1 ns after it.
  task automatic step(logic r, logic w, logic s, logic [W-1:0] d);
    rd_v = r; wr_v = w; ds = s; rd_d = d;
    @(posedge clk); #1;
    rd_v = 0; wr_v = 0; ds = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    chk_v("R1 in reset", 1'b0); chk_d("R1 in reset", '0);
    do_reset(1, 0);
    chk_v("R1 after release", 1'b0); chk_d("R1 after release", '0);
  endtask

  task automatic t_flow_read();
    do_reset(0, 0);
    step(1, 0, 0, 72'hA1_0000_1111_2222_3333);
    chk_v("R2 flow drive", 1'b1); chk_d("R2 flow data", 72'hA1_0000_1111_2222_3333);
  endtask

  task automatic t_pipe_burst();
    logic [W-1:0] b [4];
    for (int i = 0; i < 4; i++) b[i] = {8'hC0 + 8'(i), 64'h0123_4567_89AB_CDEF ^ 64'(i * 3)};
    do_reset(1, 0);
    step(1, 0, 0, b[0]);
    chk_v("R3 not yet driven", 1'b0);
    for (int i = 1; i < 4; i++) begin
      step(1, 0, 0, b[i]);
      chk_v("R10 beat drive", 1'b1); chk_d("R10 beat order", b[i-1]);
    end
    step(0, 0, 0, '0);
    chk_d("R3 last beat", b[3]);
  endtask

  task automatic t_hold();
    do_reset(0, 0);
    step(1, 0, 0, 72'h5A_DEAD_BEEF_CAFE_F00D);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 72'hFF_FFFF_FFFF_FFFF_FFFF);
    chk_v("R4 idle holds drive", 1'b1); chk_d("R4 idle holds data", 72'h5A_DEAD_BEEF_CAFE_F00D);
  endtask

  task automatic t_write();
    do_reset(0, 0);
    step(1, 0, 0, 72'h11_2233_4455_6677_8899);
    step(0, 1, 0, 72'h00_0000_0000_0000_0001);
    chk_v("R5 flow write off", 1'b0); chk_d("R5 data kept", 72'h11_2233_4455_6677_8899);
    do_reset(1, 0);
    step(1, 0, 0, 72'h22_0000_0000_0000_0002);
    step(0, 0, 0, '0);
    step(0, 1, 0, '0);
    chk_v("R5 pipe write holds one edge", 1'b1);
    step(0, 0, 0, '0);
    chk_v("R5 pipe write off", 1'b0); chk_d("R5 pipe data kept", 72'h22_0000_0000_0000_0002);
  endtask

  task automatic t_scd();
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0], 0);
      step(1, 0, 0, 72'h33_0000_0000_0000_0003);
      step(0, 0, 0, '0);
      chk_v("R6 driving before deselect", 1'b1);
      step(0, 0, 1, '0);
      chk_v("R6 scd off after capture edge", 1'b0);
    end
  endtask

  task automatic t_dcd();
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0], 1);
      step(1, 0, 0, 72'h44_0000_0000_0000_0004);
      step(0, 0, 0, '0);
      step(0, 0, 1, '0);
      chk_v("R7 dcd holds one cycle", 1'b1);
      step(0, 0, 0, '0);
      chk_v("R7 dcd off after second edge", 1'b0);
    end
    // Deselect followed at once by a read in flow-through: new data wins.
    do_reset(0, 1);
    step(1, 0, 0, 72'h55_0000_0000_0000_0005);
    step(0, 0, 1, '0);
    step(1, 0, 0, 72'h66_0000_0000_0000_0006);
    chk_v("R7 read after deselect drives", 1'b1);
    chk_d("R7 read after deselect data", 72'h66_0000_0000_0000_0006);
  endtask

  task automatic t_oe();
    do_reset(0, 0);
    step(1, 0, 0, 72'h77_0000_0000_0000_0007);
    #0.5 oe = 1'b0; #0.5;
    chk_v("R8 oe low gates at once", 1'b0); chk_d("R8 data kept", 72'h77_0000_0000_0000_0007);
    #0.5 oe = 1'b1; #0.5;
    chk_v("R8 oe high restores", 1'b1);
  endtask

  task automatic t_prio();
    do_reset(0, 1);
    step(1, 1, 1, 72'h88_0000_0000_0000_0008);
    chk_v("R9 read wins drive", 1'b1); chk_d("R9 read wins data", 72'h88_0000_0000_0000_0008);
    step(0, 1, 1, '0);
    chk_v("R9 write beats deselect", 1'b0);
  endtask

  initial begin
    t_reset();
    t_flow_read();
    t_pipe_burst();
    t_hold();
    t_write();
    t_scd();
    t_dcd();
    t_oe();
    t_prio();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule